// File: doc/BRIEF.md
# Control and status register bank with bit-alias writes

This block holds the software-visible control and status registers of a four-channel descriptor engine. It sits on a simple 32-bit register bus that does single-cycle accesses: a write is taken on the clock edge where `bus_we` is high, and a read returns the addressed register combinationally on `bus_rdata`. Every register has a base address and three alias addresses next to it. Writing the base replaces the register. Writing one of the aliases sets, clears or inverts only the bits that carry a one in the data word, so software can change single fields without a read-modify-write.

The bank holds five kinds of register. A global control register carries soft reset, clock gating, three engine option bits, per-channel interrupt enables and two read-only capability bits. A global status register carries per-channel interrupt flags next to fields that reflect live hardware state. A channel-control register carries the channel enables, the high-priority marks and an interrupt-merge option for channel 0. Each of the four channels also has a group of four general 32-bit registers. Channels raise their interrupt flags with one-cycle pulses. The bank combines the flags with their enables into one interrupt line.

Top module: `engine_csr`

## Requirements
- R1: After `rst_n` is released, every register reads zero except the control register, which reads 0x3000_0000 (both capability bits set by default), and `irq` is low.
- R2: A write to a register's base address (address bits 3:2 = 00) replaces all of its writable bits with the data word. The writable control bits are 31 (soft reset), 30 (clock gate), 23, 22, 21 and 3:0 (interrupt enables). The writable channel-control bits are 3:0, 11:8 and 16.
- R3: A write to base + 0x4 ORs the data word into the writable bits.
- R4: A write to base + 0x8 clears the writable bits that are one in the data word.
- R5: A write to base + 0xC inverts the writable bits that are one in the data word.
- R6: Control bits 29 (cipher present) and 28 (hash present) read as the parameters `HAS_CIPHER` and `HAS_HASH`, and no write of any kind changes them.
- R7: A one on `irq_set[i]` sets status flag bit i on the next edge. Software clears flags by writing a mask to the status clear alias 0x018. When a pulse and a software clear hit the same bit in the same cycle, the flag stays set.
- R8: Status bits 19:16 read `hw_ready`, bits 27:24 read `hw_cur_chan` and bit 28 reads `hw_key_ready`. Writes to the status register have no effect on these fields.
- R9: `chan_en` follows channel-control bits 3:0, `chan_prio` bits 11:8, `chan0_merge` bit 16, `irq_en` control bits 3:0, `soft_reset` control bit 31 and `clk_gate` control bit 30.
- R10: Channel c (0 to 3) register r (0 to 3) sits at 0x100 + c*0x40 + r*0x10. It is a full 32-bit read/write register and has the same three aliases.
- R11: `irq` is high exactly when some status flag and its matching interrupt enable are both one.
- R12: While the soft reset bit is one, every other register returns to its reset value on each clock, and writes and interrupt pulses to them have no effect. Writing zero to the soft reset bit releases them.
- R13: A read of any alias address returns the register's value. Reads of unmapped addresses return zero, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | AW | Byte address; bits 3:2 select the base or an alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_set | input | 4 | Per-channel interrupt-set pulses |
| hw_ready | input | 4 | Per-channel ready state shown in status |
| hw_cur_chan | input | 4 | Number of the channel currently in service |
| hw_key_ready | input | 1 | Key-ready state shown in status |
| chan_en | output | 4 | Channel enables |
| chan_prio | output | 4 | Channel high-priority marks |
| chan0_merge | output | 1 | Channel 0 interrupt merge option |
| irq_en | output | 4 | Per-channel interrupt enables |
| soft_reset | output | 1 | Soft reset bit |
| clk_gate | output | 1 | Clock gate bit |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets a hardware pulse that lands in the same cycle as a software clear of that flag. A design that lets the clear win would lose an interrupt. The bench also writes all ones, and toggles, over the capability bits and the hardware-driven status fields. A design that stored those writes would report false capabilities or stale channel state. A soft reset is held across several cycles while writes and pulses keep arriving, which exposes registers that escape the reset or that reset only once. Random alias operations are applied to all nineteen registers, with reads at alias addresses, to find wrong decoding of address bits 3:2 or of the channel stride.

// File: rtl/engine_csr.sv
module engine_csr #(
  parameter int AW = 12,
  parameter bit HAS_CIPHER = 1'b1,
  parameter bit HAS_HASH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [3:0]    irq_set,
  input  logic [3:0]    hw_ready,
  input  logic [3:0]    hw_cur_chan,
  input  logic          hw_key_ready,
  output logic [3:0]    chan_en,
  output logic [3:0]    chan_prio,
  output logic          chan0_merge,
  output logic [3:0]    irq_en,
  output logic          soft_reset,
  output logic          clk_gate,
  output logic          irq
);
  localparam int NCH = 4;
  localparam int NREG = 4;
  localparam int NGRP = NCH * NREG;
  localparam logic [31:0] CTRL_WM = 32'hC0E0_000F;
  localparam logic [31:0] CC_WM   = 32'h0001_0F0F;
  localparam logic [31:0] CAPS    = {2'b00, HAS_CIPHER, HAS_HASH, 28'h0};

  logic [31:0] ctrl_q, ctrl_n, cc_q, cc_n, st_tmp;
  logic [3:0]  flag_q, flag_n;
  logic [31:0] grp_q [NGRP];
  logic [31:0] grp_n [NGRP];

  wire [1:0]    op      = bus_addr[3:2];
  wire [AW-5:0] slot    = bus_addr[AW-1:4];
  wire          in_grp  = (bus_addr[AW-1:8] == (AW-8)'(1));
  wire [3:0]    grp_idx = bus_addr[7:4];
  wire          hit_ctrl = bus_we && slot == '0;
  wire          hit_stat = bus_we && slot == (AW-4)'(1);
  wire          hit_cc   = bus_we && slot == (AW-4)'(2);
  wire          srst = ctrl_q[31];

  function automatic logic [31:0] apply_op(input logic [31:0] old, input logic [31:0] d,
                                           input logic [1:0] o);
    case (o)
      2'd0:    return d;
      2'd1:    return old | d;
      2'd2:    return old & ~d;
      default: return old ^ d;
    endcase
  endfunction

  always_comb begin
    ctrl_n = hit_ctrl ? (apply_op(ctrl_q, bus_wdata, op) & CTRL_WM) : ctrl_q;
    if (srst) ctrl_n = ctrl_n & 32'h8000_0000;

    st_tmp = apply_op({28'h0, flag_q}, bus_wdata, op);
    flag_n = (hit_stat ? st_tmp[3:0] : flag_q) | irq_set;
    if (srst) flag_n = '0;

    cc_n = hit_cc ? (apply_op(cc_q, bus_wdata, op) & CC_WM) : cc_q;
    if (srst) cc_n = '0;

    for (int i = 0; i < NGRP; i++) begin
      grp_n[i] = (bus_we && in_grp && grp_idx == 4'(i)) ? apply_op(grp_q[i], bus_wdata, op)
                                                         : grp_q[i];
      if (srst) grp_n[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= '0;
      cc_q   <= '0;
      for (int i = 0; i < NGRP; i++) grp_q[i] <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      flag_q <= flag_n;
      cc_q   <= cc_n;
      for (int i = 0; i < NGRP; i++) grp_q[i] <= grp_n[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_grp) bus_rdata = grp_q[grp_idx];
    else if (slot == '0) bus_rdata = ctrl_q | CAPS;
    else if (slot == (AW-4)'(1))
      bus_rdata = {3'b0, hw_key_ready, hw_cur_chan, 4'b0, hw_ready, 12'h0, flag_q};
    else if (slot == (AW-4)'(2)) bus_rdata = cc_q;
  end

  assign chan_en     = cc_q[3:0];
  assign chan_prio   = cc_q[11:8];
  assign chan0_merge = cc_q[16];
  assign irq_en      = ctrl_q[3:0];
  assign soft_reset  = ctrl_q[31];
  assign clk_gate    = ctrl_q[30];
  assign irq         = |(flag_q & ctrl_q[3:0]);

  a_r6_caps_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_grp && slot == '0) |-> bus_rdata[29:28] == {HAS_CIPHER, HAS_HASH});

  a_r7_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set && !srst) |=> ((flag_q & $past(irq_set)) == $past(irq_set)));

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat && op == 2'd2 && irq_set == 4'h0 && !srst) |=>
      ((flag_q & $past(bus_wdata[3:0])) == 4'h0));

  a_r5_cc_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cc && op == 2'd3 && !srst) |=> (cc_q == ($past(cc_q) ^ ($past(bus_wdata) & CC_WM))));

  a_r12_srst_holds: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cc_q == 32'h0 && flag_q == 4'h0 && !irq));
endmodule

// File: tb/engine_csr_test.sv
module engine_csr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0] irq_set = '0, hw_ready = '0, hw_cur_chan = '0;
  logic hw_key_ready = 1'b0;
  logic [3:0] chan_en, chan_prio, irq_en;
  logic chan0_merge, soft_reset, clk_gate, irq;

  int checks = 0, fails = 0;
  logic [31:0] m_ctrl, m_cc;
  logic [3:0]  m_fl;
  logic [31:0] m_ch [16];

  engine_csr uut (.*);

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [31:0] f_op(input logic [31:0] o, input logic [31:0] d,
                                       input logic [1:0] k);
    case (k)
      2'd0: return d;
      2'd1: return o | d;
      2'd2: return o & ~d;
      default: return o ^ d;
    endcase
  endfunction

  function automatic logic [11:0] addr_of(input int idx);
    if (idx == 0) return 12'h000;
    if (idx == 1) return 12'h010;
    if (idx == 2) return 12'h020;
    return 12'h100 + 12'((idx - 3) * 16);
  endfunction

  function automatic logic [31:0] exp_rd(input int idx);
    if (idx == 0) return m_ctrl | 32'h3000_0000;
    if (idx == 1) return {3'b0, hw_key_ready, hw_cur_chan, 4'b0, hw_ready, 12'h0, m_fl};
    if (idx == 2) return m_cc;
    return m_ch[idx - 3];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input int idx, input logic [1:0] k,
                     input logic [31:0] d, input logic [3:0] set);
    bit old_s;
    logic [31:0] t;
    @(negedge clk);
    bus_we = we; bus_addr = addr_of(idx) | {8'h0, k, 2'b00}; bus_wdata = d; irq_set = set;
    @(posedge clk);
    #1 bus_we = 1'b0; irq_set = '0;
    old_s = m_ctrl[31];
    if (we && idx == 0) m_ctrl = f_op(m_ctrl, d, k) & 32'hC0E0_000F;
    if (we && idx == 1) begin t = f_op({28'h0, m_fl}, d, k); m_fl = t[3:0]; end
    m_fl = m_fl | set;
    if (we && idx == 2) m_cc = f_op(m_cc, d, k) & 32'h0001_0F0F;
    if (we && idx >= 3) m_ch[idx - 3] = f_op(m_ch[idx - 3], d, k);
    if (old_s) begin
      m_ctrl = m_ctrl & 32'h8000_0000; m_fl = '0; m_cc = '0;
      for (int i = 0; i < 16; i++) m_ch[i] = '0;
    end
  endtask

  task automatic rd(input string req, input int idx, input logic [1:0] k);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = addr_of(idx) | {8'h0, k, 2'b00};
    #1 chk(req, bus_rdata, exp_rd(idx));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m_ctrl = '0; m_cc = '0; m_fl = '0;
    for (int i = 0; i < 16; i++) m_ch[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < 19; i++) rd("R1 reset value", i, 2'd0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    cyc(1, 0, 2'd0, 32'h7FFF_FFFF, 4'h0);
    rd("R2 R6 ctrl base write", 0, 2'd0);
    chk("R9 irq_en", {28'h0, irq_en}, 32'hF);
    chk("R9 clk_gate", {31'h0, clk_gate}, 32'h1);
    cyc(1, 0, 2'd2, 32'h00E0_0000, 4'h0);
    rd("R4 ctrl clear alias", 0, 2'd0);
    cyc(1, 0, 2'd3, 32'h3000_0000, 4'h0);
    rd("R6 caps ignore toggle", 0, 2'd0);
    cyc(1, 0, 2'd2, 32'h3000_0000, 4'h0);
    rd("R6 caps ignore clear", 0, 2'd2);

    cyc(1, 2, 2'd0, 32'hFFFF_0A05, 4'h0);
    chk("R2 R9 chan_en", {28'h0, chan_en}, 32'h5);
    chk("R9 chan_prio", {28'h0, chan_prio}, 32'hA);
    chk("R9 chan0_merge", {31'h0, chan0_merge}, 32'h1);
    cyc(1, 2, 2'd1, 32'h0000_0002, 4'h0);
    chk("R3 set alias chan_en", {28'h0, chan_en}, 32'h7);
    cyc(1, 2, 2'd3, 32'h0001_0F0F, 4'h0);
    chk("R5 toggle chan_en", {28'h0, chan_en}, 32'h8);
    chk("R5 toggle chan_prio", {28'h0, chan_prio}, 32'h5);
    chk("R5 toggle merge", {31'h0, chan0_merge}, 32'h0);
    rd("R5 cc readback", 2, 2'd3);

    cyc(0, 0, 2'd0, 32'h0, 4'h5);
    rd("R7 pulse sets flags", 1, 2'd0);
    chk("R11 irq with enabled flag", {31'h0, irq}, 32'h1);
    cyc(1, 1, 2'd2, 32'h0000_0001, 4'h1);
    rd("R7 pulse wins over clear", 1, 2'd0);
    cyc(1, 1, 2'd2, 32'h0000_0004, 4'h0);
    rd("R7 clear alias clears flag", 1, 2'd2);
    cyc(1, 0, 2'd0, 32'h0000_0004, 4'h0);
    chk("R11 irq masked", {31'h0, irq}, 32'h0);
    cyc(0, 0, 2'd0, 32'h0, 4'h4);
    chk("R11 irq enabled flag", {31'h0, irq}, 32'h1);
    cyc(1, 1, 2'd0, 32'hFFFF_FFFF, 4'h0);
    rd("R8 status hw fields ignore write", 1, 2'd0);
    @(negedge clk); hw_ready = 4'hA; hw_cur_chan = 4'h3; hw_key_ready = 1'b1;
    rd("R8 status hw fields follow inputs", 1, 2'd1);

    for (int i = 3; i < 19; i++) cyc(1, i, 2'd0, 32'hC0DE_0000 + 32'(i), 4'h0);
    for (int i = 3; i < 19; i++) rd("R10 channel register", i, 2'(i));
    cyc(1, 7, 2'd3, 32'hFFFF_0000, 4'h0);
    rd("R10 channel toggle alias", 7, 2'd1);
    @(negedge clk); bus_addr = 12'h030;
    #1 chk("R13 unmapped read", bus_rdata, 32'h0);
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'h044; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1 bus_we = 1'b0;
    for (int i = 0; i < 19; i++) rd("R13 unmapped write no effect", i, 2'd0);

    cyc(1, 2, 2'd0, 32'h0000_0F0F, 4'h0);
    cyc(1, 0, 2'd1, 32'h8000_0000, 4'h0);
    chk("R9 soft_reset", {31'h0, soft_reset}, 32'h1);
    cyc(1, 2, 2'd0, 32'h0000_0003, 4'hF);
    cyc(0, 0, 2'd0, 32'h0, 4'hF);
    for (int i = 0; i < 19; i++) rd("R12 soft reset holds", i, 2'd0);
    chk("R12 chan_en in soft reset", {28'h0, chan_en}, 32'h0);
    chk("R12 irq in soft reset", {31'h0, irq}, 32'h0);
    cyc(1, 0, 2'd2, 32'h8000_0000, 4'h0);
    cyc(1, 2, 2'd0, 32'h0000_0006, 4'h0);
    chk("R12 release", {28'h0, chan_en}, 32'h6);

    for (int n = 0; n < 4000; n++) begin
      int idx;
      logic [31:0] d;
      idx = int'($urandom % 19);
      d = $urandom;
      if (idx == 0) d[31] = 1'b0;
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        hw_ready = 4'($urandom); hw_cur_chan = 4'($urandom); hw_key_ready = 1'($urandom);
      end
      cyc(1, idx, 2'($urandom), d, (($urandom % 4) == 0) ? 4'($urandom) : 4'h0);
      idx = int'($urandom % 19);
      case (idx)
        0: rd("R2 R3 R4 R5 random ctrl", idx, 2'($urandom));
        1: rd("R7 R8 random status", idx, 2'($urandom));
        2: rd("R2 R3 R4 R5 random cc", idx, 2'($urandom));
        default: rd("R10 R13 random channel", idx, 2'($urandom));
      endcase
      chk("R11 random irq", {31'h0, irq}, {31'h0, |(m_fl & m_ctrl[3:0])});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule